// File: doc/BRIEF.md
# DAC Clamp Mode Manager

This block decides, cycle by cycle, which output groups of an eight-channel DAC array are forced to their safe clamp level. There are six groups: each of the two bipolar pairs counts as one group, and each of the four auxiliary channels is a group of its own. Several sources can ask for a clamp. The first is a software clamp register with one bit per group. The second is a pair of sleep pins, each with its own group-select mask and snooze bit. The third is the alarm output, which has a group mask. The fourth is a supply-fault input, and it acts only on the two bipolar pairs, through a separate rail clamp.

Each source releases in its own way. A software bit releases as soon as it is written to zero. A sleep pin without snooze releases its groups as soon as the pin falls. A snoozed sleep pin leaves its groups clamped until the pin is low and a later write clears the group's bit. An alarm clamp is held until a write clears it. While a sleep pin holds a group, host writes to that group's clamp bit are dropped. The block stores no DAC codes. It raises a one-cycle reload strobe per group when that group leaves clamp, so the DAC can apply its stored active code straight away in either update mode.

All decisions are registered, so every output follows its cause after one clock edge.

Top module: `clamp_mgr`

## Requirements
- R1: After reset, `clampOut` and `swClamp` are 6'h3F, and `railClamp` and `reloadStrobe` are zero.
- R2: A host write that is not blocked loads `swClamp` with `swWrData`. A group with its bit at one is clamped from the next cycle. A group written to zero is released when no other source holds it.
- R3: While `sleepPin[p]` is high, every group whose bit is set in `sleepMask[p*6 +: 6]` is clamped from the next cycle. Groups not selected by that pin's mask are not affected.
- R4: With `snooze[p]` at 0, groups held only by pin p are released on the cycle after the pin goes low, with no write.
- R5: With `snooze[p]` at 1, groups that pin p clamped stay clamped after the pin falls. A later host write with the group's bit at 0, made while the pin is low, releases them.
- R6: A host write made while a sleep pin selects a group leaves that group's `swClamp` bit unchanged. A zero written to a snoozed group while its pin is still high does not release the group later.
- R7: While `alarmActive` is high, the groups set in `alarmMask` are clamped from the next cycle. They stay clamped after the alarm clears until a host write puts a 0 in their bit.
- R8: While `supplyFault` is high, both bits of `railClamp` are set and groups 0 and 1 (the bipolar pairs) are clamped from the next cycle. Groups 2 to 5 are not affected. The rail clamp clears on the cycle after the fault ends.
- R9: `reloadStrobe[g]` is high for exactly the one cycle in which `clampOut[g]` falls from 1 to 0, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| swWrEn | input | 1 | Host write strobe for the clamp register |
| swWrData | input | 6 | Clamp bits to write, one per group (bit 0,1 bipolar pairs, bits 2 to 5 auxiliary) |
| sleepPin | input | 2 | Sleep pins, active high |
| sleepMask | input | 12 | Group-select mask per pin, pin p at bits p*6 +: 6 |
| snooze | input | 2 | Snooze enable per sleep pin |
| alarmActive | input | 1 | Alarm output active |
| alarmMask | input | 6 | Groups clamped by the alarm |
| supplyFault | input | 1 | Supply out of range |
| swClamp | output | 6 | Current software clamp register |
| clampOut | output | 6 | Clamp flag per group |
| railClamp | output | 2 | Supply-rail clamp per bipolar pair |
| reloadStrobe | output | 6 | One-cycle pulse per group on clamp exit |

## Verification
On every cycle the assertions check the one-cycle entry rules: a raised sleep pin, the alarm and a supply fault each clamp their groups on the next edge. They also check that writes to pin-held bits are dropped, that an unblocked write lands in the register, and that the reload strobe lines up with each falling clamp flag. The exit rules that depend on history can only be shown by the directed scenarios. These are the snoozed release, which needs the pin to fall and a later clearing write, the alarm latch that outlives the alarm, and a clear written while the pin was still high that must leave no effect.

// File: rtl/clamp_mgr_pkg.sv
package clamp_mgr_pkg;
  localparam int unsigned GROUP_CNT   = 6;
  localparam int unsigned BIPOLAR_CNT = 2;
  localparam int unsigned PIN_CNT     = 2;
  localparam int unsigned MASK_W      = GROUP_CNT * PIN_CNT;

  typedef logic [GROUP_CNT-1:0] grpVec_t;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    grpVec_t wrAccept;  // write lands on these groups
    grpVec_t clearReq;  // accepted write carrying a zero
    grpVec_t pinHold;   // live sleep-pin hold
    grpVec_t snzSet;    // pin hold that must latch (snooze)
    grpVec_t almSet;    // alarm clamp request
    logic    railNow;   // supply fault present
  } clampCtl_t;
endpackage

// File: rtl/clamp_ctl.sv
module clamp_ctl
  import clamp_mgr_pkg::*;
(
  input  logic                swWrEn,
  input  logic [GROUP_CNT-1:0] swWrData,
  input  logic [PIN_CNT-1:0]  sleepPin,
  input  logic [MASK_W-1:0]   sleepMask,
  input  logic [PIN_CNT-1:0]  snooze,
  input  logic                alarmActive,
  input  logic [GROUP_CNT-1:0] alarmMask,
  input  logic                supplyFault,
  output clampCtl_t           ctl
);
  grpVec_t pinHoldP [PIN_CNT];
  grpVec_t snzP     [PIN_CNT];

  genvar p;
  generate
    for (p = 0; p < PIN_CNT; p++) begin : g_pin
      assign pinHoldP[p] = sleepPin[p] ? sleepMask[p*GROUP_CNT +: GROUP_CNT] : '0;
      assign snzP[p]     = snooze[p] ? pinHoldP[p] : '0;
    end
  endgenerate

  grpVec_t holdAll;
  grpVec_t snzAll;

  always_comb begin
    holdAll = '0;
    snzAll  = '0;
    for (int i = 0; i < PIN_CNT; i++) begin
      holdAll = holdAll | pinHoldP[i];
      snzAll  = snzAll | snzP[i];
    end
  end

  always_comb begin
    ctl.pinHold  = holdAll;
    ctl.snzSet   = snzAll;
    ctl.wrAccept = swWrEn ? ~holdAll : '0;
    ctl.clearReq = ctl.wrAccept & ~swWrData;
    ctl.almSet   = alarmActive ? alarmMask : '0;
    ctl.railNow  = supplyFault;
  end
endmodule

// File: rtl/clamp_dp.sv
module clamp_dp
  import clamp_mgr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  clampCtl_t              ctl,
  input  logic [GROUP_CNT-1:0]   swWrData,
  output logic [GROUP_CNT-1:0]   swClamp,
  output logic [GROUP_CNT-1:0]   clampOut,
  output logic [BIPOLAR_CNT-1:0] railClamp,
  output logic [GROUP_CNT-1:0]   reloadStrobe
);
  grpVec_t swQ, snzQ, almQ, clampQ, reloadQ;
  grpVec_t swNext, snzNext, almNext, clampNext, railVec;
  logic [BIPOLAR_CNT-1:0] railQ;

  genvar g;
  generate
    for (g = 0; g < GROUP_CNT; g++) begin : g_rail
      if (g < BIPOLAR_CNT) begin : g_bip
        assign railVec[g] = ctl.railNow;
      end else begin : g_aux
        assign railVec[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    swNext    = (swQ & ~ctl.wrAccept) | (swWrData & ctl.wrAccept);
    snzNext   = (snzQ & ~ctl.clearReq) | ctl.snzSet;
    almNext   = (almQ & ~ctl.clearReq) | ctl.almSet;
    clampNext = swNext | snzNext | almNext | ctl.pinHold | railVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swQ     <= '1;
      snzQ    <= '0;
      almQ    <= '0;
      clampQ  <= '1;
      reloadQ <= '0;
      railQ   <= '0;
    end else begin
      swQ     <= swNext;
      snzQ    <= snzNext;
      almQ    <= almNext;
      clampQ  <= clampNext;
      reloadQ <= clampQ & ~clampNext;
      railQ   <= {BIPOLAR_CNT{ctl.railNow}};
    end
  end

  assign swClamp      = swQ;
  assign clampOut     = clampQ;
  assign railClamp    = railQ;
  assign reloadStrobe = reloadQ;
endmodule

// File: rtl/clamp_mgr.sv
module clamp_mgr
  import clamp_mgr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   swWrEn,
  input  logic [GROUP_CNT-1:0]   swWrData,
  input  logic [PIN_CNT-1:0]     sleepPin,
  input  logic [MASK_W-1:0]      sleepMask,
  input  logic [PIN_CNT-1:0]     snooze,
  input  logic                   alarmActive,
  input  logic [GROUP_CNT-1:0]   alarmMask,
  input  logic                   supplyFault,
  output logic [GROUP_CNT-1:0]   swClamp,
  output logic [GROUP_CNT-1:0]   clampOut,
  output logic [BIPOLAR_CNT-1:0] railClamp,
  output logic [GROUP_CNT-1:0]   reloadStrobe
);
  clampCtl_t ctl;

  clamp_ctl u_ctl (
    .swWrEn      (swWrEn),
    .swWrData    (swWrData),
    .sleepPin    (sleepPin),
    .sleepMask   (sleepMask),
    .snooze      (snooze),
    .alarmActive (alarmActive),
    .alarmMask   (alarmMask),
    .supplyFault (supplyFault),
    .ctl         (ctl)
  );

  clamp_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .swWrData     (swWrData),
    .swClamp      (swClamp),
    .clampOut     (clampOut),
    .railClamp    (railClamp),
    .reloadStrobe (reloadStrobe)
  );
endmodule

// File: rtl/clamp_mgr_chk.sv
module clamp_mgr_chk
  import clamp_mgr_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   swWrEn,
  input logic [GROUP_CNT-1:0]   swWrData,
  input logic [PIN_CNT-1:0]     sleepPin,
  input logic [MASK_W-1:0]      sleepMask,
  input logic                   alarmActive,
  input logic [GROUP_CNT-1:0]   alarmMask,
  input logic                   supplyFault,
  input logic [GROUP_CNT-1:0]   swClamp,
  input logic [GROUP_CNT-1:0]   clampOut,
  input logic [BIPOLAR_CNT-1:0] railClamp,
  input logic [GROUP_CNT-1:0]   reloadStrobe
);
  localparam int unsigned M0 = 0;
  localparam int unsigned M1 = GROUP_CNT;

  // R2: an unblocked write lands in the register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && sleepPin == '0) |=> (swClamp == $past(swWrData)));

  // R3: pin 0 clamps its masked groups
  a_r3_pin0_clamps: assert property (@(posedge clk) disable iff (!rstN)
    sleepPin[0] |=> ((clampOut & $past(sleepMask[M0 +: GROUP_CNT])) == $past(sleepMask[M0 +: GROUP_CNT])));

  // R3: pin 1 clamps its masked groups
  a_r3_pin1_clamps: assert property (@(posedge clk) disable iff (!rstN)
    sleepPin[1] |=> ((clampOut & $past(sleepMask[M1 +: GROUP_CNT])) == $past(sleepMask[M1 +: GROUP_CNT])));

  // R6: held bits keep their value across a write
  a_r6_pin0_wr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && sleepPin[0]) |=> ((swClamp & $past(sleepMask[M0 +: GROUP_CNT])) ==
                                 ($past(swClamp) & $past(sleepMask[M0 +: GROUP_CNT]))));

  // R7: alarm clamps its masked groups
  a_r7_alarm_clamps: assert property (@(posedge clk) disable iff (!rstN)
    alarmActive |=> ((clampOut & $past(alarmMask)) == $past(alarmMask)));

  // R8: supply fault sets the rail clamp on both pairs
  a_r8_rail_clamp: assert property (@(posedge clk) disable iff (!rstN)
    supplyFault |=> (railClamp == '1 && clampOut[BIPOLAR_CNT-1:0] == '1));

  // R9: reload strobe coincides with each falling clamp flag
  a_r9_reload_on_exit: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (reloadStrobe == ($past(clampOut) & ~clampOut)));
endmodule

bind clamp_mgr clamp_mgr_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .swWrEn       (swWrEn),
  .swWrData     (swWrData),
  .sleepPin     (sleepPin),
  .sleepMask    (sleepMask),
  .alarmActive  (alarmActive),
  .alarmMask    (alarmMask),
  .supplyFault  (supplyFault),
  .swClamp      (swClamp),
  .clampOut     (clampOut),
  .railClamp    (railClamp),
  .reloadStrobe (reloadStrobe)
);

// File: tb/clamp_mgr_test.sv
module clamp_mgr_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0;
  logic [5:0]  swWrData = '0;
  logic [1:0]  sleepPin = '0;
  logic [11:0] sleepMask = '0;
  logic [1:0]  snooze = '0;
  logic        alarmActive = 1'b0;
  logic [5:0]  alarmMask = '0;
  logic        supplyFault = 1'b0;
  logic [5:0]  swClamp, clampOut, reloadStrobe;
  logic [1:0]  railClamp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  clamp_mgr uut (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
    .sleepPin(sleepPin), .sleepMask(sleepMask), .snooze(snooze),
    .alarmActive(alarmActive), .alarmMask(alarmMask), .supplyFault(supplyFault),
    .swClamp(swClamp), .clampOut(clampOut), .railClamp(railClamp),
    .reloadStrobe(reloadStrobe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [5:0] d);
    swWrEn = 1'b1;
    swWrData = d;
    step(1);
    swWrEn = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk("R1 clampOut", {2'b0, clampOut}, 8'h3F);
    chk("R1 swClamp", {2'b0, swClamp}, 8'h3F);
    chk("R1 railClamp", {6'b0, railClamp}, 8'h00);
    chk("R1 reloadStrobe", {2'b0, reloadStrobe}, 8'h00);
  endtask

  task automatic t_soft();
    hostWrite(6'h00);
    chk("R2 release all", {2'b0, clampOut}, 8'h00);
    chk("R9 reload on exit", {2'b0, reloadStrobe}, 8'h3F);
    step(1);
    chk("R9 reload one cycle", {2'b0, reloadStrobe}, 8'h00);
    hostWrite(6'h05);
    chk("R2 set bits", {2'b0, clampOut}, 8'h05);
    chk("R2 register", {2'b0, swClamp}, 8'h05);
    chk("R9 no strobe on entry", {2'b0, reloadStrobe}, 8'h00);
    hostWrite(6'h00);
    chk("R2 clear bits", {2'b0, clampOut}, 8'h00);
    chk("R9 reload subset", {2'b0, reloadStrobe}, 8'h05);
  endtask

  task automatic t_sleepPlain();
    sleepMask = {6'h30, 6'h06};
    snooze = 2'b00;
    sleepPin = 2'b01;
    step(1);
    chk("R3 pin0 masked groups only", {2'b0, clampOut}, 8'h06);
    sleepPin = 2'b00;
    step(1);
    chk("R4 pin low releases", {2'b0, clampOut}, 8'h00);
    chk("R9 reload after sleep", {2'b0, reloadStrobe}, 8'h06);
  endtask

  task automatic t_sleepSnooze();
    snooze = 2'b10;
    sleepPin = 2'b10;
    step(1);
    chk("R3 pin1 masked groups", {2'b0, clampOut}, 8'h30);
    hostWrite(6'h3F);
    chk("R6 held bits unchanged", {2'b0, swClamp}, 8'h0F);
    hostWrite(6'h00);
    chk("R6 clear while high", {2'b0, swClamp}, 8'h00);
    sleepPin = 2'b00;
    step(2);
    chk("R5 snoozed stays clamped", {2'b0, clampOut}, 8'h30);
    chk("R6 early clear not armed", {2'b0, reloadStrobe}, 8'h00);
    hostWrite(6'h00);
    chk("R5 write releases", {2'b0, clampOut}, 8'h00);
    chk("R9 reload after snooze", {2'b0, reloadStrobe}, 8'h30);
    snooze = 2'b00;
  endtask

  task automatic t_alarm();
    alarmMask = 6'h09;
    alarmActive = 1'b1;
    step(1);
    chk("R7 alarm clamps", {2'b0, clampOut}, 8'h09);
    alarmActive = 1'b0;
    step(2);
    chk("R7 latched after alarm", {2'b0, clampOut}, 8'h09);
    hostWrite(6'h00);
    chk("R7 write releases", {2'b0, clampOut}, 8'h00);
  endtask

  task automatic t_supply();
    supplyFault = 1'b1;
    step(1);
    chk("R8 rail clamp", {6'b0, railClamp}, 8'h03);
    chk("R8 bipolar only", {2'b0, clampOut}, 8'h03);
    supplyFault = 1'b0;
    step(1);
    chk("R8 rail cleared", {6'b0, railClamp}, 8'h00);
    chk("R8 released", {2'b0, clampOut}, 8'h00);
    chk("R9 reload after fault", {2'b0, reloadStrobe}, 8'h03);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    t_reset();
    t_soft();
    t_sleepPlain();
    t_sleepSnooze();
    t_alarm();
    t_supply();
    step(2);
    summary();
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end
endmodule